// File: doc/BRIEF.md
# Raster Scan Coordinate Counter

This block produces the horizontal and vertical coordinates of a video raster scan. The horizontal count advances on every clock. When it reaches the end value of the line it returns to zero, and the vertical count then steps once. When the vertical count is already at its end value, the vertical count returns to zero instead, which ends the frame. The two end values come from a small table that is indexed by a video-mode select input. A new mode is taken only at a frame boundary.

The terminal-count tests are done one cycle early and held in registered wrap flags. As a result, the comparator and the incrementer of each axis sit on separate register-to-register paths. The sequence seen at the ports is the same as that of a plain counter that compares and wraps in the same cycle.

Two single-cycle markers give the last pixel of each line and the last pixel of each frame. Sync and blanking pulses are not generated here. The block that uses these counts decodes them.

Top module: `raster_scan_counter`

## Requirements
- R1: While `rst` is high at a clock edge, both counts load 0. `line_last` and `frame_last` read 0 after that edge, and the mode on `mode_sel` becomes the active mode.
- R2: While the horizontal count is below the active line end value, it rises by exactly one per clock. On the clock after it equals that end value, it is 0. A line therefore lasts end value + 1 cycles.
- R3: The vertical count holds its value on every clock edge at which the horizontal count is not at the line end value.
- R4: When the horizontal count is at the line end value, the vertical count rises by one at the next edge. If the vertical count is already at the frame end value, both counts return to 0 instead.
- R5: With the 2-bit mode value m, the line end value is H_BASE + H_STEP*m and the frame end value is V_BASE + V_STEP*m. The defaults are 9 + 4m and 5 + 2m.
- R6: A change on `mode_sel` has no effect until the edge that ends the current frame. That edge samples `mode_sel`, and the new limits apply from the next cycle.
- R7: `line_last` is high exactly on the cycles where the horizontal count equals the line end value. `frame_last` is high exactly on the cycles where, in addition, the vertical count equals the frame end value.
- R8: Over any run of cycles and mode changes, the counts and markers equal those of a counter that compares against the end value and wraps in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | MODE_W | Requested video mode; sampled at reset and at each frame end |
| hcnt | output | CNT_W | Horizontal coordinate |
| vcnt | output | CNT_W | Vertical coordinate |
| line_last | output | 1 | High on the last pixel of every line |
| frame_last | output | 1 | High on the last pixel of the frame |

## Verification
The hardest case to reach is a mode request that arrives in the middle of a frame. In that case the old limits must stay in force for every remaining line, and the new limits must start on the exact cycle after the frame ends. The stimulus changes `mode_sel` partway through a line, waits for the frame end, and checks that each line before it still ends at the old value and that the first line after it ends at the new one. A long run that changes mode at an interval unrelated to the frame length is also compared cycle by cycle against a same-cycle reference model, so that mode changes land at arbitrary positions within the frame.

// File: rtl/raster_pkg.sv
package raster_pkg;
  // Terminal value of one axis for a given mode index: base + step * idx.
  function automatic int end_value(int base, int step, int idx);
    return base + step * idx;
  endfunction
endpackage

// File: rtl/raster_mode_table.sv
module raster_mode_table #(
  parameter int MODE_W = 2,
  parameter int CNT_W  = 12,
  parameter int H_BASE = 9,
  parameter int H_STEP = 4,
  parameter int V_BASE = 5,
  parameter int V_STEP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              frame_wrap,
  output logic [CNT_W-1:0]  h_end,
  output logic [CNT_W-1:0]  h_cmp,
  output logic [CNT_W-1:0]  v_end
);
  localparam int NUM_MODES = 1 << MODE_W;

  logic [CNT_W-1:0] h_tab [NUM_MODES];
  logic [CNT_W-1:0] v_tab [NUM_MODES];

  // One table row per mode, computed from base and step.
  for (genvar i = 0; i < NUM_MODES; i++) begin : g_row
    assign h_tab[i] = CNT_W'(raster_pkg::end_value(H_BASE, H_STEP, i));
    assign v_tab[i] = CNT_W'(raster_pkg::end_value(V_BASE, V_STEP, i));
  end

  // Limits are loaded only at reset or on the frame-ending edge.
  always_ff @(posedge clk) begin
    if (rst || frame_wrap) begin
      h_end <= h_tab[mode_sel];
      h_cmp <= h_tab[mode_sel] - 1'b1;
      v_end <= v_tab[mode_sel];
    end
  end

  // R6
  limits_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_wrap |=> ($stable(h_end) && $stable(v_end)));
endmodule

// File: rtl/raster_axis_counter.sv
module raster_axis_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic [CNT_W-1:0] cmp_value,
  output logic [CNT_W-1:0] count,
  output logic             wrap_flag
);
  // The wrap flag is computed from the present count and acts on the next
  // advance, so the compare never sits in front of the incrementer.
  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      wrap_flag <= 1'b0;
    end else begin
      if (advance) begin
        if (wrap_flag) count <= '0;
        else           count <= count + 1'b1;
      end
      if (advance && wrap_flag) wrap_flag <= 1'b0;
      else                      wrap_flag <= (count == cmp_value);
    end
  end

  // R2
  axis_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && wrap_flag) |=> (count == '0));

  // R2
  axis_step_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !wrap_flag) |=> (count == $past(count) + 1'b1));

  // R3
  axis_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(count));
endmodule

// File: rtl/raster_scan_counter.sv
module raster_scan_counter #(
  parameter int MODE_W = 2,
  parameter int CNT_W  = 12,
  parameter int H_BASE = 9,
  parameter int H_STEP = 4,
  parameter int V_BASE = 5,
  parameter int V_STEP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_sel,
  output logic [CNT_W-1:0]  hcnt,
  output logic [CNT_W-1:0]  vcnt,
  output logic              line_last,
  output logic              frame_last
);
  logic [CNT_W-1:0] h_end, h_cmp, v_end;
  logic             h_flag, v_flag, frame_wrap;

  assign frame_wrap = h_flag & v_flag;

  raster_mode_table #(
    .MODE_W(MODE_W), .CNT_W(CNT_W),
    .H_BASE(H_BASE), .H_STEP(H_STEP), .V_BASE(V_BASE), .V_STEP(V_STEP)
  ) u_table (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .frame_wrap(frame_wrap),
    .h_end(h_end), .h_cmp(h_cmp), .v_end(v_end)
  );

  // Horizontal axis: advances every cycle, flags one count before the end.
  raster_axis_counter #(.CNT_W(CNT_W)) u_hax (
    .clk(clk), .rst(rst), .advance(1'b1), .cmp_value(h_cmp),
    .count(hcnt), .wrap_flag(h_flag)
  );

  // Vertical axis: advances on line wraps, flags while at its end value.
  raster_axis_counter #(.CNT_W(CNT_W)) u_vax (
    .clk(clk), .rst(rst), .advance(h_flag), .cmp_value(v_end),
    .count(vcnt), .wrap_flag(v_flag)
  );

  assign line_last  = h_flag;
  assign frame_last = frame_wrap;

  // R7
  line_marker_chk: assert property (@(posedge clk) disable iff (rst)
    (hcnt == h_end) == line_last);

  // R7
  frame_marker_chk: assert property (@(posedge clk) disable iff (rst)
    frame_last |-> (vcnt == v_end && hcnt == h_end));

  // R2
  h_range_chk: assert property (@(posedge clk) disable iff (rst)
    hcnt <= h_end);

  // R4
  v_range_chk: assert property (@(posedge clk) disable iff (rst)
    vcnt <= v_end);
endmodule

// File: tb/tb_raster_scan_counter.sv
`timescale 1ns/1ps
module tb_raster_scan_counter;
  localparam int MODE_W = 2;
  localparam int CNT_W  = 12;
  localparam int HB = 9, HS = 4, VB = 5, VS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [MODE_W-1:0] mode_sel = '0;
  logic [CNT_W-1:0] hcnt, vcnt;
  logic line_last, frame_last;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  raster_scan_counter #(
    .MODE_W(MODE_W), .CNT_W(CNT_W),
    .H_BASE(HB), .H_STEP(HS), .V_BASE(VB), .V_STEP(VS)
  ) dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel),
    .hcnt(hcnt), .vcnt(vcnt), .line_last(line_last), .frame_last(frame_last)
  );

  function automatic int hend_of(int m); return HB + HS * m; endfunction
  function automatic int vend_of(int m); return VB + VS * m; endfunction

  // Same-cycle reference counter
  int rh = 0, rv = 0, ract = 0;
  always @(posedge clk) begin
    if (rst) begin
      rh = 0; rv = 0; ract = int'(mode_sel);
    end else if (rh == hend_of(ract)) begin
      rh = 0;
      if (rv == vend_of(ract)) begin
        rv = 0; ract = int'(mode_sel);
      end else rv = rv + 1;
    end else rh = rh + 1;
  end

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmp_ref(string tag);
    int ell, efl;
    ell = (rh == hend_of(ract)) ? 1 : 0;
    efl = (ell == 1 && rv == vend_of(ract)) ? 1 : 0;
    check({tag, " hcnt"}, int'(hcnt), rh);
    check({tag, " vcnt"}, int'(vcnt), rv);
    check({tag, " line_last"}, int'(line_last), ell);
    check({tag, " frame_last"}, int'(frame_last), efl);
  endtask

  task automatic do_reset(int m);
    @(negedge clk);
    rst = 1'b1;
    mode_sel = MODE_W'(m);
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_line();
    @(negedge clk);
    while (!line_last) @(negedge clk);
  endtask

  task automatic wait_frame();
    @(negedge clk);
    while (!frame_last) @(negedge clk);
  endtask

  // R1: reset clears counts and markers, even from a running state
  task automatic t_reset();
    do_reset(1);
    repeat (37) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 hcnt", int'(hcnt), 0);
    check("R1 vcnt", int'(vcnt), 0);
    check("R1 line_last", int'(line_last), 0);
    check("R1 frame_last", int'(frame_last), 0);
    rst = 1'b0;
    cmp_ref("R1");
  endtask

  // R2 / R7: horizontal sweep and markers across several lines
  task automatic t_hsweep();
    do_reset(1);
    for (int i = 0; i < 3 * (hend_of(1) + 1); i++) begin
      @(negedge clk);
      cmp_ref("R2");
    end
    wait_line();
    check("R7 hcnt at line_last", int'(hcnt), hend_of(1));
    @(negedge clk);
    check("R2 hcnt after wrap", int'(hcnt), 0);
  endtask

  // R3 / R4: vertical stepping and frame wrap
  task automatic t_vstep();
    do_reset(0);
    for (int i = 0; i < 80; i++) begin
      int v0, ll;
      v0 = int'(vcnt);
      ll = int'(line_last);
      @(negedge clk);
      if (ll == 0) check("R3 vcnt hold", int'(vcnt), v0);
      else check("R4 vcnt step", int'(vcnt), (v0 == vend_of(0)) ? 0 : v0 + 1);
    end
    wait_frame();
    check("R4 vcnt at frame_last", int'(vcnt), vend_of(0));
    @(negedge clk);
    check("R4 vcnt after frame", int'(vcnt), 0);
    check("R4 hcnt after frame", int'(hcnt), 0);
  endtask

  // R5: each table row gives the expected limits
  task automatic t_table();
    for (int m = 0; m < (1 << MODE_W); m++) begin
      do_reset(m);
      wait_line();
      check("R5 line end", int'(hcnt), hend_of(m));
      wait_frame();
      check("R5 frame end", int'(vcnt), vend_of(m));
    end
  endtask

  // R6: mode request in mid-frame waits for the frame end
  task automatic t_mode_switch();
    do_reset(0);
    repeat (15) @(negedge clk);
    mode_sel = 2'd3;
    wait_line();
    check("R6 old line end", int'(hcnt), hend_of(0));
    wait_frame();
    check("R6 old frame end v", int'(vcnt), vend_of(0));
    check("R6 old frame end h", int'(hcnt), hend_of(0));
    @(negedge clk);
    check("R6 restart h", int'(hcnt), 0);
    wait_line();
    check("R6 new line end", int'(hcnt), hend_of(3));
  endtask

  // R8: long run vs same-cycle reference with arbitrary mode changes
  task automatic t_reference();
    do_reset(2);
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      cmp_ref("R8");
      if (i % 37 == 36) mode_sel = mode_sel + 2'd1;
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_hsweep();
    t_vstep();
    t_table();
    t_mode_switch();
    t_reference();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule